// File: doc/BRIEF.md
# Character-clock raster timing generator

This block produces the raster timing for a display controller. It runs on the pixel clock and keeps two position counters. The horizontal counter advances in character cells of eight pixels. The vertical counter advances in scan lines. The block compares the counter positions against programmed limits. From those comparisons it drives display-enable, blanking and the two sync strobes. It also reports the pixel position that belongs to each strobe.

The limits use offset encodings. The line length is the programmed total plus five characters. The frame length is the programmed total plus two lines. The display-enable limits are inclusive last positions, and the sync limits are shifted by one. Software can therefore program the limits directly from the active size, the margins and the sync widths. The timing limits are copied into shadow registers only at a frame boundary, so a frame is never built from a mix of old and new values.

A few power-management controls act on the very next cycle, and none of them waits for a frame boundary:
- a screen-off control forces blanking while both syncs keep running;
- two suppression bits hold either sync at its idle level;
- a polarity bit for each sync sets its active level.

Top module: `crtc_timing_gen`

## Requirements
- R1: Each character lasts 8 pixel clocks. A line lasts `cfg_h_total`+5 characters. `pix_x_o` counts 0 up to (`cfg_h_total`+5)*8-1 and then returns to 0. Valid `cfg_h_total` values are at most 2^HW-5.
- R2: A frame lasts `cfg_v_total`+2 lines. `pix_y_o` counts from 0 up to `cfg_v_total`+1, advances when `pix_x_o` wraps, and returns to 0 after the last line.
- R3: `de_o` is high when the character index c ≤ `cfg_h_de_end`, the line l ≤ `cfg_v_de_end`, and the screen is on.
- R4: `blank_o` is high when c ≥ `cfg_h_bl_start`, when l ≥ `cfg_v_bl_start`, or when the screen is off.
- R5: The horizontal sync is active when `cfg_h_sy_start` ≤ c+1 < `cfg_h_sy_end`. When the end value is not above the start value, the horizontal sync never becomes active.
- R6: The vertical sync is active when `cfg_v_sy_start`+1 ≤ l < `cfg_v_sy_end`+1. When the end value is not above the start value, the vertical sync never becomes active.
- R7: A sync drives the level of its polarity input (`hs_pol` or `vs_pol`) when active and the inverse when idle; 1 means active-high. A polarity change shows in the next cycle's output.
- R8: `sync_off[0]`=1 holds `hsync_o` at its idle level. `sync_off[1]`=1 holds `vsync_o` at its idle level. The value 2'b11 holds both. Each takes effect on the next cycle's output.
- R9: `screen_off`=1 forces `blank_o` high and `de_o` low on the next cycle's output. Sync generation is not affected.
- R10: Timing limits written during a frame are ignored until the first pixel of the following frame. From that pixel on, both the counters and the strobes use the new limits.
- R11: All outputs are registered. During reset, `de_o`=0, `blank_o`=1, both syncs are idle, and the position is 0,0. The first cycle after reset reports position 0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; also loads the shadow limits |
| cfg_h_total | input | HW | Characters per line minus 5 |
| cfg_h_de_end | input | HW | Last character with display enabled |
| cfg_h_bl_start | input | HW | First blanked character |
| cfg_h_sy_start | input | HW | Horizontal sync start, character index plus 1 |
| cfg_h_sy_end | input | HW | Horizontal sync end (exclusive), character index plus 1 |
| cfg_v_total | input | VW | Lines per frame minus 2 |
| cfg_v_de_end | input | VW | Last line with display enabled |
| cfg_v_bl_start | input | VW | First blanked line |
| cfg_v_sy_start | input | VW | Vertical sync start, line index minus 1 |
| cfg_v_sy_end | input | VW | Vertical sync end (exclusive), line index minus 1 |
| sync_off | input | 2 | Bit 0 suppresses horizontal sync, bit 1 suppresses vertical sync |
| screen_off | input | 1 | Forces blanking while syncs keep running |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking strobe |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| pix_x_o | output | HW+3 | Pixel column of the current strobes |
| pix_y_o | output | VW | Scan line of the current strobes |

## Verification
The delicate coincidence is the frame boundary. In that single cycle, the character counter wraps, the line counter wraps, and the shadow limits reload from the inputs. The following line length must therefore come from the new total, and not from the old one. The bench provokes this by rewriting every limit in the middle of a frame, with a new line length and a new frame length. A reference model loads its own copy of the limits only at its own frame wrap. Every output field is then compared each cycle across that boundary and for the frames after it. A second overlap puts screen-off together with sync suppression, to confirm that each acts on its own output only.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned PIX_PER_CHAR_W = 3;
  localparam int unsigned NUM_WIN        = 3;
  localparam int unsigned WIN_DE         = 0;
  localparam int unsigned WIN_BLANK      = 1;
  localparam int unsigned WIN_SYNC       = 2;
  localparam int unsigned HS_OFF_BIT     = 0;
  localparam int unsigned VS_OFF_BIT     = 1;
endpackage

// File: rtl/crtc_char_counter.sv
module crtc_char_counter #(
  parameter int unsigned HW  = 8,
  parameter int unsigned PXW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] last_char_i,
  output logic [HW-1:0] char_o,
  output logic [PXW-1:0] pix_o,
  output logic          line_end_o
);
  localparam logic [PXW-1:0] PIX_LAST = '1;

  assign line_end_o = (pix_o == PIX_LAST) && (char_o == last_char_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_o <= '0;
      pix_o  <= '0;
    end else if (line_end_o) begin
      char_o <= '0;
      pix_o  <= '0;
    end else begin
      pix_o <= pix_o + 1'b1;
      if (pix_o == PIX_LAST) char_o <= char_o + 1'b1;
    end
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_end_o |=> (char_o == '0) && (pix_o == '0)); // R1
  AST_CHAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_o != PIX_LAST) |=> $stable(char_o)); // R1
endmodule

// File: rtl/crtc_line_counter.sv
module crtc_line_counter #(
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [VW-1:0] last_line_i,
  output logic [VW-1:0] line_o,
  output logic          frame_end_o
);
  assign frame_end_o = step_i && (line_o == last_line_i);

  always_ff @(posedge clk) begin
    if (rst)              line_o <= '0;
    else if (frame_end_o) line_o <= '0;
    else if (step_i)      line_o <= line_o + 1'b1;
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(line_o)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> (line_o == '0)); // R2
endmodule

// File: rtl/crtc_window.sv
module crtc_window #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         hit_o
);
  assign hit_o = (pos_i >= lo_i) && (pos_i < hi_i);
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int unsigned HW = 8,
  parameter int unsigned VW = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [HW-1:0]               cfg_h_total,
  input  logic [HW-1:0]               cfg_h_de_end,
  input  logic [HW-1:0]               cfg_h_bl_start,
  input  logic [HW-1:0]               cfg_h_sy_start,
  input  logic [HW-1:0]               cfg_h_sy_end,
  input  logic [VW-1:0]               cfg_v_total,
  input  logic [VW-1:0]               cfg_v_de_end,
  input  logic [VW-1:0]               cfg_v_bl_start,
  input  logic [VW-1:0]               cfg_v_sy_start,
  input  logic [VW-1:0]               cfg_v_sy_end,
  input  logic [1:0]                  sync_off,
  input  logic                        screen_off,
  input  logic                        hs_pol,
  input  logic                        vs_pol,
  output logic                        de_o,
  output logic                        blank_o,
  output logic                        hsync_o,
  output logic                        vsync_o,
  output logic [HW+PIX_PER_CHAR_W-1:0] pix_x_o,
  output logic [VW-1:0]               pix_y_o
);
  localparam int unsigned PXW = PIX_PER_CHAR_W;
  localparam int unsigned HCW = HW + 1;
  localparam int unsigned VCW = VW + 1;

  // shadow copies of the timing limits, reloaded at frame boundaries only
  logic [HW-1:0] sh_ht, sh_hde, sh_hbs, sh_hss, sh_hse;
  logic [VW-1:0] sh_vt, sh_vde, sh_vbs, sh_vss, sh_vse;

  logic [HW-1:0]  hc;
  logic [PXW-1:0] px;
  logic [VW-1:0]  vc;
  logic           line_end, frame_end;
  logic [HW-1:0]  h_last;
  logic [VW-1:0]  v_last;

  assign h_last = sh_ht + HW'(4);
  assign v_last = sh_vt + VW'(1);

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      sh_ht  <= cfg_h_total;
      sh_hde <= cfg_h_de_end;
      sh_hbs <= cfg_h_bl_start;
      sh_hss <= cfg_h_sy_start;
      sh_hse <= cfg_h_sy_end;
      sh_vt  <= cfg_v_total;
      sh_vde <= cfg_v_de_end;
      sh_vbs <= cfg_v_bl_start;
      sh_vss <= cfg_v_sy_start;
      sh_vse <= cfg_v_sy_end;
    end
  end

  crtc_char_counter #(.HW(HW), .PXW(PXW)) u_char (
    .clk         (clk),
    .rst         (rst),
    .last_char_i (h_last),
    .char_o      (hc),
    .pix_o       (px),
    .line_end_o  (line_end)
  );

  crtc_line_counter #(.VW(VW)) u_line (
    .clk         (clk),
    .rst         (rst),
    .step_i      (line_end),
    .last_line_i (v_last),
    .line_o      (vc),
    .frame_end_o (frame_end)
  );

  // window bounds, one extra bit so that end+1 never wraps
  logic [HCW-1:0] h_pos [NUM_WIN];
  logic [HCW-1:0] h_lo  [NUM_WIN];
  logic [HCW-1:0] h_hi  [NUM_WIN];
  logic [VCW-1:0] v_pos [NUM_WIN];
  logic [VCW-1:0] v_lo  [NUM_WIN];
  logic [VCW-1:0] v_hi  [NUM_WIN];
  logic [NUM_WIN-1:0] h_hit, v_hit;

  always_comb begin
    h_pos[WIN_DE]    = {1'b0, hc};
    h_lo[WIN_DE]     = '0;
    h_hi[WIN_DE]     = {1'b0, sh_hde} + 1'b1;
    h_pos[WIN_BLANK] = {1'b0, hc};
    h_lo[WIN_BLANK]  = {1'b0, sh_hbs};
    h_hi[WIN_BLANK]  = '1;
    h_pos[WIN_SYNC]  = {1'b0, hc} + 1'b1;
    h_lo[WIN_SYNC]   = {1'b0, sh_hss};
    h_hi[WIN_SYNC]   = {1'b0, sh_hse};
    v_pos[WIN_DE]    = {1'b0, vc};
    v_lo[WIN_DE]     = '0;
    v_hi[WIN_DE]     = {1'b0, sh_vde} + 1'b1;
    v_pos[WIN_BLANK] = {1'b0, vc};
    v_lo[WIN_BLANK]  = {1'b0, sh_vbs};
    v_hi[WIN_BLANK]  = '1;
    v_pos[WIN_SYNC]  = {1'b0, vc};
    v_lo[WIN_SYNC]   = {1'b0, sh_vss} + 1'b1;
    v_hi[WIN_SYNC]   = {1'b0, sh_vse} + 1'b1;
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    crtc_window #(.W(HCW)) u_hwin (
      .pos_i (h_pos[k]),
      .lo_i  (h_lo[k]),
      .hi_i  (h_hi[k]),
      .hit_o (h_hit[k])
    );
    crtc_window #(.W(VCW)) u_vwin (
      .pos_i (v_pos[k]),
      .lo_i  (v_lo[k]),
      .hi_i  (v_hi[k]),
      .hit_o (v_hit[k])
    );
  end

  logic hs_act, vs_act;
  assign hs_act = h_hit[WIN_SYNC] && !sync_off[HS_OFF_BIT];
  assign vs_act = v_hit[WIN_SYNC] && !sync_off[VS_OFF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o    <= 1'b0;
      blank_o <= 1'b1;
      hsync_o <= !hs_pol;
      vsync_o <= !vs_pol;
      pix_x_o <= '0;
      pix_y_o <= '0;
    end else begin
      de_o    <= h_hit[WIN_DE] && v_hit[WIN_DE] && !screen_off;
      blank_o <= h_hit[WIN_BLANK] || v_hit[WIN_BLANK] || screen_off;
      hsync_o <= hs_act ? hs_pol : !hs_pol;
      vsync_o <= vs_act ? vs_pol : !vs_pol;
      pix_x_o <= {hc, px};
      pix_y_o <= vc;
    end
  end

  AST_SCREEN_OFF_BLANK: assert property (@(posedge clk) disable iff (rst)
    screen_off |=> blank_o && !de_o); // R9
  AST_HS_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    sync_off[HS_OFF_BIT] |=> (hsync_o == !$past(hs_pol))); // R8
  AST_VS_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    sync_off[VS_OFF_BIT] |=> (vsync_o == !$past(vs_pol))); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(sh_ht) && $stable(sh_hde) && $stable(sh_hbs) && $stable(sh_hss)
                && $stable(sh_hse) && $stable(sh_vt) && $stable(sh_vde) && $stable(sh_vbs)
                && $stable(sh_vss) && $stable(sh_vse)); // R10
  AST_DE_IN_DISPLAY: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !$past(screen_off)); // R3
endmodule

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int VW = 11;
  localparam int XW = HW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] cfg_h_total, cfg_h_de_end, cfg_h_bl_start, cfg_h_sy_start, cfg_h_sy_end;
  logic [VW-1:0] cfg_v_total, cfg_v_de_end, cfg_v_bl_start, cfg_v_sy_start, cfg_v_sy_end;
  logic [1:0] sync_off = 2'b00;
  logic screen_off = 1'b0;
  logic hs_pol = 1'b1;
  logic vs_pol = 1'b1;
  logic de_o, blank_o, hsync_o, vsync_o;
  logic [XW-1:0] pix_x_o;
  logic [VW-1:0] pix_y_o;

  crtc_timing_gen #(.HW(HW), .VW(VW)) u_crtc_timing_gen (
    .clk(clk), .rst(rst),
    .cfg_h_total(cfg_h_total), .cfg_h_de_end(cfg_h_de_end), .cfg_h_bl_start(cfg_h_bl_start),
    .cfg_h_sy_start(cfg_h_sy_start), .cfg_h_sy_end(cfg_h_sy_end),
    .cfg_v_total(cfg_v_total), .cfg_v_de_end(cfg_v_de_end), .cfg_v_bl_start(cfg_v_bl_start),
    .cfg_v_sy_start(cfg_v_sy_start), .cfg_v_sy_end(cfg_v_sy_end),
    .sync_off(sync_off), .screen_off(screen_off), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .de_o(de_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit in_reset;
    bit de, blank, hs, vs;
    int x, y;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state, loaded only at its own frame wrap
  int m_x, m_y;
  int s_ht, s_hde, s_hbs, s_hss, s_hse, s_vt, s_vde, s_vbs, s_vss, s_vse;

  task automatic load_model();
    s_ht  = int'(cfg_h_total);    s_hde = int'(cfg_h_de_end);
    s_hbs = int'(cfg_h_bl_start); s_hss = int'(cfg_h_sy_start);
    s_hse = int'(cfg_h_sy_end);   s_vt  = int'(cfg_v_total);
    s_vde = int'(cfg_v_de_end);   s_vbs = int'(cfg_v_bl_start);
    s_vss = int'(cfg_v_sy_start); s_vse = int'(cfg_v_sy_end);
  endtask

  task automatic set_cfg(int ht, int hde, int hbs, int hss, int hse,
                         int vt, int vde, int vbs, int vss, int vse);
    cfg_h_total    = HW'(ht);  cfg_h_de_end   = HW'(hde);
    cfg_h_bl_start = HW'(hbs); cfg_h_sy_start = HW'(hss);
    cfg_h_sy_end   = HW'(hse); cfg_v_total    = VW'(vt);
    cfg_v_de_end   = VW'(vde); cfg_v_bl_start = VW'(vbs);
    cfg_v_sy_start = VW'(vss); cfg_v_sy_end   = VW'(vse);
  endtask

  // driver side: predict the output of every edge and queue it
  always @(posedge clk) begin : model
    exp_t e;
    int c;
    bit hs_act, vs_act;
    if (rst) begin
      e.in_reset = 1'b1; e.de = 1'b0; e.blank = 1'b1;
      e.hs = !hs_pol; e.vs = !vs_pol; e.x = 0; e.y = 0;
      sb_q.push_back(e);
      m_x = 0; m_y = 0;
      load_model();
    end else begin
      c = m_x / 8;
      e.in_reset = 1'b0;
      e.de    = (c <= s_hde) && (m_y <= s_vde) && !screen_off;
      e.blank = (c >= s_hbs) || (m_y >= s_vbs) || screen_off;
      hs_act  = (c + 1 >= s_hss) && (c + 1 < s_hse) && !sync_off[0];
      vs_act  = (m_y >= s_vss + 1) && (m_y < s_vse + 1) && !sync_off[1];
      e.hs = hs_act ? hs_pol : !hs_pol;
      e.vs = vs_act ? vs_pol : !vs_pol;
      e.x = m_x; e.y = m_y;
      sb_q.push_back(e);
      m_x = m_x + 1;
      if (m_x == (s_ht + 5) * 8) begin
        m_x = 0;
        m_y = m_y + 1;
        if (m_y == s_vt + 2) begin
          m_y = 0;
          load_model();
        end
      end
    end
  end

  task automatic chk(string tag, string what, int got, int want);
    checks++;
    if (got != want) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, want, $time);
    end
  endtask

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin : monitor
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (e.in_reset) begin
        chk("R11", "de",    int'(de_o),    int'(e.de));
        chk("R11", "blank", int'(blank_o), int'(e.blank));
        chk("R11", "hsync", int'(hsync_o), int'(e.hs));
        chk("R11", "vsync", int'(vsync_o), int'(e.vs));
        chk("R11", "x",     int'(pix_x_o), e.x);
        chk("R11", "y",     int'(pix_y_o), e.y);
      end else begin
        chk("R3/R9",    "de",    int'(de_o),    int'(e.de));
        chk("R4/R9",    "blank", int'(blank_o), int'(e.blank));
        chk("R5/R7/R8", "hsync", int'(hsync_o), int'(e.hs));
        chk("R6/R7/R8", "vsync", int'(vsync_o), int'(e.vs));
        chk("R1/R10",   "x",     int'(pix_x_o), e.x);
        chk("R2/R10",   "y",     int'(pix_y_o), e.y);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // config A: 10 chars x 12 lines
    set_cfg(5, 5, 6, 8, 9, 10, 7, 8, 8, 10);
    run(3);                    // R11 reset values
    rst = 1'b0;
    run(2000);                 // R1 R2 R3 R4 R5 R6 basic frames
    hs_pol = 1'b0; vs_pol = 1'b0;
    run(1000);                 // R7 active-low syncs
    hs_pol = 1'b0; vs_pol = 1'b1;
    run(500);                  // R7 mixed polarity
    sync_off = 2'b01; run(500);  // R8 hsync held idle
    sync_off = 2'b10; run(500);  // R8 vsync held idle
    sync_off = 2'b11; run(500);  // R8 both held idle
    screen_off = 1'b1; run(400); // R9 with both syncs held
    sync_off = 2'b00; run(700);  // R9 screen off, syncs running
    screen_off = 1'b0;
    run(300);
    // R10: config B written mid-frame, new line and frame length
    set_cfg(3, 3, 5, 1, 3, 6, 4, 4, 0, 2);
    run(2000);
    // R5 R6 empty sync windows, R10 another mid-frame change
    set_cfg(9, 9, 10, 4, 4, 5, 2, 3, 4, 2);
    run(1500);
    // R11 reset in the middle of a frame
    rst = 1'b1; run(2);
    rst = 1'b0; run(300);
    run(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule